// File: doc/BRIEF.md
# Shared Level-Interrupt Aggregator with Bridge Remapping

This block merges the level-sensitive interrupt pins of several devices onto a small set of shared interrupt lines. Every device drives four pins. A fixed rotation picks, for each device and pin, the shared line it lands on. Each line keeps a running count of how many of its sources are asserted. The line is driven high while that count is above zero.

A second group of devices sits behind a bridge, which occupies one device slot on the root bus. A pin from a device behind the bridge is first rotated into one of the bridge's four pins. That bridge pin is then rotated again, as if the bridge itself had raised it, before it reaches the root counters.

Pin edges are found by comparing each input with its stored level. Only changes touch the counters: a rise adds one and a fall subtracts one. Several sources may change in the same cycle and on the same line.

Top module: `intx_aggregator`

## Requirements
- R1: Each device has four pins. Pin p of root device d is bit 4*d+p of `root_pins`, and pin p of secondary device s is bit 4*s+p of `sub_pins`. A 1 means asserted.
- R2: Pin p of root device d feeds line (d + p) mod NUM_LINES.
- R3: Pin p of secondary device s becomes bridge pin (s + p) mod 4. That bridge pin feeds line (BRIDGE_SLOT + bridge pin) mod NUM_LINES.
- R4: A line is high exactly when at least one of the sources that map to it is asserted. Dropping one source leaves the line high while another mapped source is still high.
- R5: Only a change of level moves a counter. A level held for any number of cycles is counted once.
- R6: A line reflects a pin change after the next rising clock edge, and not before it.
- R7: Changes on several sources that share a line in the same cycle are all counted.
- R8: Synchronous active-high reset clears the stored levels, the counters and the lines. Pins that are high when reset is released count as new rises.
- R9: A counter never goes below zero and never exceeds the total number of sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_pins | input | 4*NUM_DEV | Pin levels of the devices on the root bus |
| sub_pins | input | 4*NUM_SUB | Pin levels of the devices behind the bridge |
| irq_line | output | NUM_LINES | Registered shared interrupt lines |

## Verification
The bench builds the block with three root devices, two secondary devices, the bridge in slot 5 and four lines. With this configuration, every one of the 4096 root pin patterns can be stepped through in order, one after the other. Each step flips a different subset of pins, so the counters see many mixed rises and falls.

The secondary pins are walked one at a time and then mixed in from a pseudo-random sequence, which exercises the double rotation across the bridge. Further cases drive three sources that share one line, hold levels across several cycles, and apply reset while pins are high.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int PINS_PER_DEV = 4;

  function automatic int rotate_pin(input int dev, input int pin, input int modulus);
    return (dev + pin) % modulus;
  endfunction
endpackage

// File: rtl/intx_level_tracker.sv
module intx_level_tracker #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] level,
  output logic [N_SRC-1:0] rise,
  output logic [N_SRC-1:0] fall
);
  logic [N_SRC-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else     seen_q <= level;
  end

  assign rise = level & ~seen_q;
  assign fall = ~level & seen_q;
endmodule

// File: rtl/intx_router.sv
module intx_router
  import intx_pkg::*;
#(
  parameter int NUM_DEV     = 4,
  parameter int NUM_SUB     = 4,
  parameter int BRIDGE_SLOT = 6,
  parameter int NUM_LINES   = 4,
  parameter int CNT_W       = 6
) (
  input  logic [(NUM_DEV+NUM_SUB)*PINS_PER_DEV-1:0] rise,
  input  logic [(NUM_DEV+NUM_SUB)*PINS_PER_DEV-1:0] fall,
  output logic [NUM_LINES-1:0][CNT_W-1:0]           inc_sum,
  output logic [NUM_LINES-1:0][CNT_W-1:0]           dec_sum
);
  localparam int N_ROOT = NUM_DEV * PINS_PER_DEV;
  localparam int N_SRC  = (NUM_DEV + NUM_SUB) * PINS_PER_DEV;

  logic [N_SRC-1:0][NUM_LINES-1:0] sel;

  for (genvar k = 0; k < N_SRC; k++) begin : g_map
    localparam int PIN = k % PINS_PER_DEV;
    localparam int LN  = (k < N_ROOT)
      ? rotate_pin(k / PINS_PER_DEV, PIN, NUM_LINES)
      : rotate_pin(BRIDGE_SLOT,
                   rotate_pin((k - N_ROOT) / PINS_PER_DEV, PIN, PINS_PER_DEV),
                   NUM_LINES);
    assign sel[k] = NUM_LINES'(1) << LN;
  end

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      inc_sum[l] = '0;
      dec_sum[l] = '0;
      for (int k = 0; k < N_SRC; k++) begin
        inc_sum[l] = inc_sum[l] + CNT_W'(rise[k] & sel[k][l]);
        dec_sum[l] = dec_sum[l] + CNT_W'(fall[k] & sel[k][l]);
      end
    end
  end
endmodule

// File: rtl/intx_line_counter.sv
module intx_line_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] inc,
  input  logic [CNT_W-1:0] dec,
  output logic [CNT_W-1:0] cnt,
  output logic             line
);
  logic [CNT_W-1:0] cnt_n;

  assign cnt_n = cnt + inc - dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      line <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      line <= (cnt_n != '0);
    end
  end
endmodule

// File: rtl/intx_aggregator.sv
module intx_aggregator
  import intx_pkg::*;
#(
  parameter int NUM_DEV     = 4,
  parameter int NUM_SUB     = 4,
  parameter int BRIDGE_SLOT = 6,
  parameter int NUM_LINES   = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_DEV*PINS_PER_DEV-1:0] root_pins,
  input  logic [NUM_SUB*PINS_PER_DEV-1:0] sub_pins,
  output logic [NUM_LINES-1:0]            irq_line
);
  localparam int N_SRC = (NUM_DEV + NUM_SUB) * PINS_PER_DEV;
  localparam int CNT_W = $clog2(N_SRC + 1);

  logic [N_SRC-1:0]                rise, fall;
  logic [NUM_LINES-1:0][CNT_W-1:0] inc_sum, dec_sum, line_cnt;

  intx_level_tracker #(.N_SRC(N_SRC)) u_track (
    .clk  (clk),
    .rst  (rst),
    .level({sub_pins, root_pins}),
    .rise (rise),
    .fall (fall)
  );

  intx_router #(
    .NUM_DEV    (NUM_DEV),
    .NUM_SUB    (NUM_SUB),
    .BRIDGE_SLOT(BRIDGE_SLOT),
    .NUM_LINES  (NUM_LINES),
    .CNT_W      (CNT_W)
  ) u_route (
    .rise   (rise),
    .fall   (fall),
    .inc_sum(inc_sum),
    .dec_sum(dec_sum)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    intx_line_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (inc_sum[l]),
      .dec (dec_sum[l]),
      .cnt (line_cnt[l]),
      .line(irq_line[l])
    );
  end
endmodule

// File: rtl/intx_aggregator_chk.sv
module intx_aggregator_chk #(
  parameter int NUM_LINES = 4,
  parameter int CNT_W     = 6,
  parameter int MAX_CNT   = 32,
  parameter int ROOT_W    = 16,
  parameter int SUB_W     = 16
) (
  input logic                            clk,
  input logic                            rst,
  input logic [ROOT_W-1:0]               root_pins,
  input logic [SUB_W-1:0]                sub_pins,
  input logic [NUM_LINES-1:0]            irq_line,
  input logic [NUM_LINES-1:0][CNT_W-1:0] line_cnt,
  input logic [NUM_LINES-1:0][CNT_W-1:0] inc_sum,
  input logic [NUM_LINES-1:0][CNT_W-1:0] dec_sum
);
  // R8
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_line == '0));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(root_pins) && $stable(sub_pins)) |=> $stable(irq_line));

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, dec_sum[l]} <= ({1'b0, line_cnt[l]} + {1'b0, inc_sum[l]})));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(line_cnt[l]) <= MAX_CNT));

    // R4
    line_tracks_cnt_chk: assert property (@(posedge clk) disable iff (rst)
      irq_line[l] == (line_cnt[l] != '0));
  end
endmodule

bind intx_aggregator intx_aggregator_chk #(
  .NUM_LINES(NUM_LINES),
  .CNT_W    (CNT_W),
  .MAX_CNT  (N_SRC),
  .ROOT_W   (NUM_DEV * 4),
  .SUB_W    (NUM_SUB * 4)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .root_pins(root_pins),
  .sub_pins (sub_pins),
  .irq_line (irq_line),
  .line_cnt (line_cnt),
  .inc_sum  (inc_sum),
  .dec_sum  (dec_sum)
);

// File: tb/tb_intx_aggregator.sv
module tb_intx_aggregator;
  localparam int ND = 3, NS = 2, BS = 5, NL = 4;
  localparam int RW = ND * 4, SW = NS * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] root_pins = '0;
  logic [SW-1:0] sub_pins  = '0;
  logic [NL-1:0] irq_line;
  logic [NL-1:0] cur_exp = '0;
  int nvec = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intx_aggregator #(.NUM_DEV(ND), .NUM_SUB(NS), .BRIDGE_SLOT(BS), .NUM_LINES(NL)) dut (
    .clk(clk), .rst(rst), .root_pins(root_pins), .sub_pins(sub_pins), .irq_line(irq_line));

  // R2 / R3 / R4 model: count asserted sources per line
  function automatic logic [NL-1:0] model(input logic [RW-1:0] r, input logic [SW-1:0] s);
    int cnt[NL];
    logic [NL-1:0] res;
    for (int l = 0; l < NL; l++) cnt[l] = 0;
    for (int d = 0; d < ND; d++)
      for (int p = 0; p < 4; p++)
        if (r[d*4+p]) cnt[(d + p) % NL]++;
    for (int sd = 0; sd < NS; sd++)
      for (int p = 0; p < 4; p++)
        if (s[sd*4+p]) cnt[(BS + ((sd + p) % 4)) % NL]++;
    for (int l = 0; l < NL; l++) res[l] = (cnt[l] != 0);
    return res;
  endfunction

  task automatic check(input string tag, input logic [NL-1:0] exp);
    nvec++;
    if (irq_line !== exp) begin
      nfail++;
      $display("FAIL %s: irq_line=%b expected=%b", tag, irq_line, exp);
    end
  endtask

  // R6: old value right after drive, new value one edge later
  task automatic apply(input string tag, input logic [RW-1:0] r, input logic [SW-1:0] s);
    @(negedge clk);
    root_pins = r;
    sub_pins  = s;
    #1 check({"R6 ", tag}, cur_exp);
    cur_exp = model(r, s);
    @(negedge clk);
    check(tag, cur_exp);
  endtask

  initial begin
    int unsigned lfsr;
    lfsr = 32'hACE1_1234;
    // R8: pins high during reset do not reach the lines
    root_pins = '1;
    sub_pins  = '1;
    repeat (3) @(negedge clk);
    check("R8 reset", '0);
    rst = 1'b0;
    #1 check("R8 first cycle", '0);
    @(negedge clk);
    cur_exp = model('1, '1);
    check("R8 rises after release", cur_exp);
    apply("R8 all low", '0, '0);

    // R1 / R2 / R3: single-pin walk
    for (int k = 0; k < RW; k++) begin
      apply("R2 root walk", RW'(1) << k, '0);
      apply("R2 root clear", '0, '0);
    end
    for (int k = 0; k < SW; k++) begin
      apply("R3 sub walk", '0, SW'(1) << k);
      apply("R3 sub clear", '0, '0);
    end

    // R7: three sources on line 1 change together, then drop one by one (R4)
    apply("R7 joint rise", RW'(12'h012), SW'(8'h01));
    apply("R4 one left two", RW'(12'h010), SW'(8'h01));
    apply("R4 one left one", RW'(12'h000), SW'(8'h01));
    apply("R4 last dropped", '0, '0);

    // R5: hold levels for several cycles, then release
    apply("R5 hold set", RW'(12'hA5A), SW'(8'h3C));
    repeat (4) begin
      @(negedge clk);
      check("R5 held", cur_exp);
    end
    apply("R5 partial release", RW'(12'h005), SW'(8'h00));
    apply("R5 full release", '0, '0);

    // R4 / R7: exhaustive sweep of root patterns with a moving sub pattern
    for (int v = 0; v < (1 << RW); v++)
      apply("R4 sweep", RW'(v), SW'(v >> 4));

    // R7: pseudo-random multi-pin toggles
    for (int i = 0; i < 1500; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8020_0003 : 32'h0);
      apply("R7 random", lfsr[RW-1:0], lfsr[RW+SW-1:RW]);
    end

    // R8: mid-run reset with pins held high
    apply("R8 pre", RW'(12'hFFF), SW'(8'hF0));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid reset", '0);
    rst = 1'b0;
    @(negedge clk);
    cur_exp = model(RW'(12'hFFF), SW'(8'hF0));
    check("R8 recount", cur_exp);
    apply("R8 clean drop", '0, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule